// File: doc/BRIEF.md
# Single-Clock FIFO with Selectable Look-Ahead Read

This block is a first-in first-out word buffer that runs on one clock. A producer presents a word together with a write strobe. Both are captured on the same rising edge, so the two signals need no offset between them. A consumer pulls words with a read strobe. The `empty` flag, the `full` flag and a word count report how much the buffer holds. Depth and word width are parameters.

The parameter `SHOW_AHEAD` selects one of two read modes.

- **Look-ahead mode (`SHOW_AHEAD = 1`).** The oldest word is already on `rd_data` whenever `empty` is low. A read strobe discards that word, and the next word appears after the same edge.
- **Fetch mode (`SHOW_AHEAD = 0`).** A read strobe starts a fetch. The word appears on `rd_data` one cycle later, after the edge that sampled the strobe.

In both modes, a word written into a buffer with no readable word needs two further edges before `empty` drops.

A head state machine controls the read side. It has three states:

- `HD_IDLE`: no word is readable.
- `HD_ARM`: a word is stored and the head is settling.
- `HD_HOLD`: a readable word exists.

It has these transitions:

- `IDLE→ARM`: the memory holds at least one word.
- `ARM→HOLD`: unconditional. In look-ahead mode this transition also loads the head word into the output register.
- `HOLD→HOLD`: a read that leaves a word readable.
- `HOLD→IDLE`: a read that takes the last word.
- Any state `→IDLE`: on `clr`.

Top module: `sync_fifo_sa`

## Requirements
- R1: Words leave in the order they were written, and each word is the `wr_data` value sampled on the same edge as its `wr_req`.
- R2: When `wr_req` is sampled at edge k while `level` is 0, `empty` stays 1 after edges k and k+1 and is 0 after edge k+2 (if no read or clear intervenes).
- R3: In look-ahead mode, while `empty` is 0, `rd_data` equals the oldest stored word and holds steady until a read is accepted.
- R4: In look-ahead mode, a read accepted at an edge puts the next stored word on `rd_data` right after that edge. If no word remains, `empty` is 1 after that edge.
- R5: In fetch mode, a read accepted at an edge places the oldest word on `rd_data` after that edge and not before. `rd_data` holds otherwise.
- R6: A write while `full` is 1 is dropped: `level` and the stored words are unchanged.
- R7: A read while `empty` is 1 is dropped: `level` and the read order are unchanged.
- R8: A read and a write at the same edge, with `empty` 0 and `full` 0, leave `level` unchanged.
- R9: `full` is 1 exactly when `level` equals `DEPTH`, in the same cycle.
- R10: `clr` high at an edge leaves `empty` 1, `full` 0 and `level` 0 after it. `clr` wins over a write at that edge.
- R11: `level` counts every stored word, including a word held on `rd_data` in look-ahead mode.
- R12: After reset, `empty` is 1, `full` is 0 and `level` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear that empties the buffer |
| wr_req | input | 1 | Write strobe |
| wr_data | input | WIDTH | Word to write, sampled with `wr_req` |
| rd_req | input | 1 | Read strobe |
| rd_data | output | WIDTH | Head word (look-ahead mode) or fetched word (fetch mode) |
| empty | output | 1 | 1 when no word is readable |
| full | output | 1 | 1 when `level` equals `DEPTH` |
| level | output | $clog2(DEPTH+1) | Number of stored words |

## Verification
A wrong pointer or count shows at the ports within one edge. The symptom is either a `level` that fails to move by exactly the accepted writes minus the accepted reads, or a word on `rd_data` that is out of order. A head state machine stuck in the wrong state shows as an `empty` flag that drops one edge early or late after a write into an idle buffer. It can also show as a look-ahead word that changes without a read. A broken clear or full gate is visible on the edge right after the stimulus, through `level` and `full`.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    // head state machine encoding
    typedef enum logic [1:0] {
        HD_IDLE = 2'd0,   // no readable word
        HD_ARM  = 2'd1,   // word stored, head settling
        HD_HOLD = 2'd2    // readable word present
    } head_state_e;

    function automatic int unsigned addr_bits(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    function automatic int unsigned count_bits(input int unsigned depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/fifo_store.sv
module fifo_store
    import sfifo_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WIDTH = 8,
    localparam int unsigned AW   = addr_bits(DEPTH),
    localparam int unsigned CW   = count_bits(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    mem_cnt
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr;
    logic [AW-1:0]    rptr;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else if (clr) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push) begin
                wptr <= step(wptr);
            end
            if (pop) begin
                rptr <= step(rptr);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_cnt <= '0;
        end else if (clr) begin
            mem_cnt <= '0;
        end else begin
            unique case ({push, pop})
                2'b10:   mem_cnt <= mem_cnt + 1'b1;
                2'b01:   mem_cnt <= mem_cnt - 1'b1;
                default: mem_cnt <= mem_cnt;
            endcase
        end
    end

    assign head = mem[rptr];

endmodule

// File: rtl/fifo_head_fsm.sv
module fifo_head_fsm
    import sfifo_pkg::*;
#(
    parameter int unsigned WIDTH      = 8,
    parameter int unsigned CW         = 5,
    parameter bit          SHOW_AHEAD = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             rd_req,
    input  logic             push,
    input  logic [CW-1:0]    mem_cnt,
    input  logic [WIDTH-1:0] head,
    output logic             pop,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             held
);

    head_state_e st;
    head_state_e nxt;
    logic        mem_nz;
    logic        mem_one;
    logic        rd_ok;
    logic        pop_raw;

    assign mem_nz  = (mem_cnt != '0);
    assign mem_one = (mem_cnt == CW'(1));
    assign rd_ok   = rd_req && (st == HD_HOLD);

    generate
        if (SHOW_AHEAD) begin : g_look
            always_comb begin
                nxt     = st;
                pop_raw = 1'b0;
                unique case (st)
                    HD_IDLE: begin
                        if (mem_nz) nxt = HD_ARM;
                    end
                    HD_ARM: begin
                        pop_raw = 1'b1;
                        nxt     = HD_HOLD;
                    end
                    HD_HOLD: begin
                        if (rd_ok) begin
                            if (mem_nz) pop_raw = 1'b1;
                            else        nxt     = HD_IDLE;
                        end
                    end
                    default: nxt = HD_IDLE;
                endcase
            end
        end else begin : g_fetch
            always_comb begin
                nxt     = st;
                pop_raw = 1'b0;
                unique case (st)
                    HD_IDLE: begin
                        if (mem_nz) nxt = HD_ARM;
                    end
                    HD_ARM: begin
                        nxt = HD_HOLD;
                    end
                    HD_HOLD: begin
                        if (rd_ok) begin
                            pop_raw = 1'b1;
                            if (mem_one && !push) nxt = HD_IDLE;
                        end
                    end
                    default: nxt = HD_IDLE;
                endcase
            end
        end
    endgenerate

    assign pop = pop_raw && !clr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   st <= HD_IDLE;
        else if (clr) st <= HD_IDLE;
        else          st <= nxt;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   rd_data <= '0;
        else if (pop) rd_data <= head;
    end

    assign empty = (st != HD_HOLD);
    assign held  = SHOW_AHEAD && (st == HD_HOLD);

endmodule

// File: rtl/fifo_level.sv
module fifo_level #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CW    = 5
) (
    input  logic [CW-1:0] mem_cnt,
    input  logic          held,
    output logic [CW-1:0] level,
    output logic          full
);

    localparam logic [CW-1:0] TOP = CW'(DEPTH);

    assign level = mem_cnt + CW'(held);
    assign full  = (level == TOP);

endmodule

// File: rtl/sync_fifo_sa.sv
module sync_fifo_sa
    import sfifo_pkg::*;
#(
    parameter int unsigned DEPTH      = 16,
    parameter int unsigned WIDTH      = 8,
    parameter bit          SHOW_AHEAD = 1'b1,
    localparam int unsigned CW        = count_bits(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_req,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_req,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full,
    output logic [CW-1:0]    level
);

    logic             push;
    logic             pop;
    logic             held;
    logic [CW-1:0]    mem_cnt;
    logic [WIDTH-1:0] head;

    assign push = wr_req && !full && !clr;

    fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .push    (push),
        .wdata   (wr_data),
        .pop     (pop),
        .head    (head),
        .mem_cnt (mem_cnt)
    );

    fifo_head_fsm #(.WIDTH(WIDTH), .CW(CW), .SHOW_AHEAD(SHOW_AHEAD)) u_head (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .rd_req  (rd_req),
        .push    (push),
        .mem_cnt (mem_cnt),
        .head    (head),
        .pop     (pop),
        .rd_data (rd_data),
        .empty   (empty),
        .held    (held)
    );

    fifo_level #(.DEPTH(DEPTH), .CW(CW)) u_level (
        .mem_cnt (mem_cnt),
        .held    (held),
        .level   (level),
        .full    (full)
    );

endmodule

// File: rtl/sync_fifo_sa_chk.sv
module sync_fifo_sa_chk #(
    parameter int unsigned DEPTH      = 16,
    parameter int unsigned WIDTH      = 8,
    parameter bit          SHOW_AHEAD = 1'b1,
    parameter int unsigned CW         = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             wr_req,
    input logic             rd_req,
    input logic [WIDTH-1:0] rd_data,
    input logic             empty,
    input logic             full,
    input logic [CW-1:0]    level
);

    localparam logic [CW-1:0] NEAR = CW'(DEPTH - 1);
    localparam logic [CW-1:0] TOP  = CW'(DEPTH);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_req && !rd_req && !clr) |=> $stable(level));

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !wr_req && !clr) |=> $stable(level));

    // R8
    rw_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !full && wr_req && rd_req && !clr) |=> $stable(level));

    // R9
    fill_to_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == NEAR && wr_req && !rd_req && !clr) |=> (full && level == TOP));

    // R10
    clear_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (empty && !full && level == '0));

    // R2
    settle_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0 && wr_req && !clr) |=> empty ##1 empty);

    generate
        if (SHOW_AHEAD) begin : g_look
            // R3
            head_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!empty && !rd_req) |=> $stable(rd_data));
        end else begin : g_fetch
            // R5
            fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(rd_req && !empty) |=> $stable(rd_data));
        end
    endgenerate

endmodule

bind sync_fifo_sa sync_fifo_sa_chk #(
    .DEPTH(DEPTH), .WIDTH(WIDTH), .SHOW_AHEAD(SHOW_AHEAD), .CW(CW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_req(wr_req), .rd_req(rd_req),
    .rd_data(rd_data), .empty(empty), .full(full), .level(level)
);

// File: tb/test_sync_fifo_sa.sv
`timescale 1ns/1ps
module test_sync_fifo_sa;

    localparam int unsigned DEPTH = 4;
    localparam int unsigned WIDTH = 8;
    localparam int unsigned CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    // look-ahead instance
    logic             a_clr = 1'b0, a_wr = 1'b0, a_rd = 1'b0;
    logic [WIDTH-1:0] a_wd = '0, a_q;
    logic             a_empty, a_full;
    logic [CW-1:0]    a_lvl;

    // fetch-mode instance
    logic             n_clr = 1'b0, n_wr = 1'b0, n_rd = 1'b0;
    logic [WIDTH-1:0] n_wd = '0, n_q;
    logic             n_empty, n_full;
    logic [CW-1:0]    n_lvl;

    sync_fifo_sa #(.DEPTH(DEPTH), .WIDTH(WIDTH), .SHOW_AHEAD(1'b1)) i_sync_fifo_sa (
        .clk(clk), .rst_n(rst_n), .clr(a_clr), .wr_req(a_wr), .wr_data(a_wd),
        .rd_req(a_rd), .rd_data(a_q), .empty(a_empty), .full(a_full), .level(a_lvl)
    );

    sync_fifo_sa #(.DEPTH(DEPTH), .WIDTH(WIDTH), .SHOW_AHEAD(1'b0)) i_sync_fifo_sa_fetch (
        .clk(clk), .rst_n(rst_n), .clr(n_clr), .wr_req(n_wr), .wr_data(n_wd),
        .rd_req(n_rd), .rd_data(n_q), .empty(n_empty), .full(n_full), .level(n_lvl)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // wait for an edge, then settle away from it
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // look-ahead vector: wr, wdata, rd, clr | empty, full, level, check-data, data
    localparam int NV = 18;
    localparam logic [24:0] VEC [NV] = '{
        {1'b1, 8'h11, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 1'b0, 8'h00}, // R2 write into idle buffer
        {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 1'b0, 8'h00}, // R2 still settling
        {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 1'b1, 8'h11}, // R2/R3 head visible
        {1'b1, 8'h22, 1'b0, 1'b0, 1'b0, 1'b0, 3'd2, 1'b1, 8'h11}, // R11
        {1'b1, 8'h33, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 1'b1, 8'h11},
        {1'b1, 8'h44, 1'b0, 1'b0, 1'b0, 1'b1, 3'd4, 1'b1, 8'h11}, // R9 full
        {1'b1, 8'h55, 1'b0, 1'b0, 1'b0, 1'b1, 3'd4, 1'b1, 8'h11}, // R6 dropped write
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 3'd3, 1'b1, 8'h22}, // R4 advance
        {1'b1, 8'h66, 1'b1, 1'b0, 1'b0, 1'b0, 3'd3, 1'b1, 8'h33}, // R8 read+write
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 3'd2, 1'b1, 8'h44}, // R1 order
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 3'd1, 1'b1, 8'h66},
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00}, // R4 last word taken
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00}, // R7 read on empty
        {1'b1, 8'h77, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 1'b0, 8'h00},
        {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 1'b0, 8'h00},
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 3'd1, 1'b1, 8'h77}, // R7 read while settling
        {1'b1, 8'h88, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00}, // R10 clear beats write
        {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00}
    };

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R12 reset state
        chk("R12 empty", a_empty, 1'b1);
        chk("R12 full",  a_full,  1'b0);
        chk("R12 level", a_lvl,   '0);
        chk("R12 empty fetch", n_empty, 1'b1);

        // look-ahead table
        for (int i = 0; i < NV; i++) begin
            a_wr  = VEC[i][24];
            a_wd  = VEC[i][23:16];
            a_rd  = VEC[i][15];
            a_clr = VEC[i][14];
            step();
            chk("R2 empty", a_empty, VEC[i][13]);
            chk("R9 full",  a_full,  VEC[i][12]);
            chk("R11 level", a_lvl,  VEC[i][11:9]);
            if (VEC[i][8]) chk("R3 head data", a_q, VEC[i][7:0]);
        end
        a_wr = 1'b0; a_rd = 1'b0; a_clr = 1'b0;

        // fetch mode: settle delay and one-cycle read latency
        n_wr = 1'b1; n_wd = 8'hA0; step();
        chk("R2 fetch empty k", n_empty, 1'b1);
        n_wd = 8'hA1; step();
        chk("R2 fetch empty k+1", n_empty, 1'b1);
        n_wd = 8'hA2; step();
        chk("R2 fetch empty k+2", n_empty, 1'b0);
        chk("R11 fetch level", n_lvl, 3'd3);
        n_wr = 1'b0; n_rd = 1'b1;
        chk("R5 no data on request cycle", n_q, 8'h00);
        step();
        chk("R5 fetched", n_q, 8'hA0);
        chk("R5 level", n_lvl, 3'd2);
        n_rd = 1'b0; step();
        chk("R5 held", n_q, 8'hA0);
        n_rd = 1'b1; step();
        chk("R1 fetch order", n_q, 8'hA1);
        step();
        chk("R1 fetch order last", n_q, 8'hA2);
        chk("R7 fetch empty", n_empty, 1'b1);
        step();
        chk("R7 read on empty data", n_q, 8'hA2);
        chk("R7 read on empty level", n_lvl, 3'd0);
        n_rd = 1'b0;

        // fetch mode: fill past depth
        n_wr = 1'b1;
        for (int k = 0; k < 5; k++) begin
            n_wd = 8'hB0 + 8'(k);
            step();
        end
        n_wr = 1'b0;
        chk("R9 fetch full", n_full, 1'b1);
        chk("R6 fetch level", n_lvl, 3'd4);
        n_rd = 1'b1;
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R6 fetch drain order", n_q, 8'hB0 + 8'(k));
        end
        n_rd = 1'b0;
        chk("R6 fetch drained", n_empty, 1'b1);
        chk("R9 fetch not full", n_full, 1'b0);

        // look-ahead: clear from a partly filled buffer
        a_wr = 1'b1; a_wd = 8'hC0; step();
        a_wd = 8'hC1; step();
        a_wr = 1'b0; step();
        chk("R3 head before clear", a_q, 8'hC0);
        a_clr = 1'b1; step();
        a_clr = 1'b0;
        chk("R10 clear empty", a_empty, 1'b1);
        chk("R10 clear level", a_lvl, 3'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule